// File: doc/BRIEF.md
# Two-Thread Instruction Issue Selector

This block sits between a shared decode stage and the shared execution units of a core that runs two hardware threads. Decode writes each instruction, tagged with its thread, into that thread's own four-entry queue. In every cycle the selector dispatches at most one instruction, taken from the head of one queue. It drives the instruction to the integer, floating-point or load/store unit named by the instruction's unit class, and it labels the dispatch with the thread it came from.

Each thread owns a register set and a program counter inside the block. A change of issuing thread therefore costs no cycle and needs no state save or restore. Turn-taking is fair only while both threads are able to issue. A thread whose queue is empty, or whose head instruction needs a unit that is busy, is passed over in that same cycle. The other thread then issues instead, so the block does not sit idle.

Top module: `smt_issue_top`

## Requirements
- R1: Each thread has its own queue of DEPTH (default 4) entries. An enqueue goes to the queue named by `enq_tid`. `q_full[t]` is high while queue t holds DEPTH entries. An enqueue into a full queue is ignored and has no effect on the other thread's queue.
- R2: When both threads can issue, the selected thread alternates from cycle to cycle. A priority pointer decides the choice, and after every issue it passes to the thread that did not issue.
- R3: A thread cannot issue in a cycle when its queue is empty or when `unit_busy` is high for the unit its head instruction needs. If the other thread can issue, it issues in that same cycle, whatever the pointer holds.
- R4: When neither thread can issue, `iss_valid` is low and the priority pointer keeps its value.
- R5: The class codes are 0 for the integer ALU, 1 for the floating-point unit and 2 for the load/store unit. Code 3 goes to the ALU. `iss_unit` is one-hot, with bit 0 for the ALU, bit 1 for the FPU and bit 2 for the LSU. `unit_busy` uses the same bit order.
- R6: Every dispatch presents `iss_tid`, `iss_dest` and `iss_data` taken from the head of that thread's queue. Each queue issues its entries in arrival order.
- R7: At the clock edge of an issue, `iss_data` is written into register `iss_dest` of the issuing thread only, and that thread's program counter advances by one. The other thread's registers and program counter are left unchanged.
- R8: Synchronous reset empties both queues, clears every register and both program counters, and gives thread 0 first priority.
- R9: The issue outputs are combinational from the queue heads and `unit_busy`. An instruction enqueued at one clock edge can issue in the following cycle.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Decode presents an instruction |
| enq_tid | input | 1 | Thread the instruction belongs to |
| enq_unit | input | 2 | Unit class code |
| enq_dest | input | 2 | Destination register index |
| enq_data | input | 8 | Result value carried by the instruction |
| q_full | output | 2 | Per-thread queue full |
| unit_busy | input | 3 | Busy flags for ALU, FPU, LSU |
| iss_valid | output | 1 | An instruction is dispatched this cycle |
| iss_tid | output | 1 | Thread of the dispatched instruction |
| iss_unit | output | 3 | One-hot unit selection |
| iss_dest | output | 2 | Destination register of the dispatch |
| iss_data | output | 8 | Data of the dispatch |
| rd_tid | input | 1 | Thread whose register set is read |
| rd_addr | input | 2 | Register index to read |
| rd_data | output | 8 | Register read data |
| pc_t0 | output | 8 | Program counter of thread 0 |
| pc_t1 | output | 8 | Program counter of thread 1 |

## Verification
The hardest case to reach from the ports is a thread issuing out of turn: both queues must hold entries whose head units differ, and exactly the unit of the favoured thread's head must be busy. The bench first fills both queues while every unit is held busy, so nothing drains. It then steps a table of per-cycle busy patterns that were chosen against the known order of the queued units. The same walk covers a cycle where both heads are blocked, so the pointer must hold, and later cycles where alternation has to resume from that held value.

// File: rtl/smt_issue_pkg.sv
package smt_issue_pkg;

    localparam int NUM_THREADS = 2;
    localparam int NUM_UNITS   = 3;
    localparam int DATA_W      = 8;
    localparam int REG_AW      = 2;

    typedef enum logic [1:0] {
        UC_ALU  = 2'd0,
        UC_FPU  = 2'd1,
        UC_LSU  = 2'd2,
        UC_RSVD = 2'd3
    } unit_class_e;

    typedef struct packed {
        unit_class_e          unit;
        logic [REG_AW-1:0]    dest;
        logic [DATA_W-1:0]    data;
    } instr_t;

    // Class code to one-hot unit select; the reserved code routes to the ALU.
    function automatic logic [NUM_UNITS-1:0] unit_onehot(unit_class_e uc);
        case (uc)
            UC_FPU:  return 3'b010;
            UC_LSU:  return 3'b100;
            default: return 3'b001;
        endcase
    endfunction

endpackage

// File: rtl/thread_fifo.sv
module thread_fifo
    import smt_issue_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  instr_t push_instr,
    input  logic   pop,
    output logic   full,
    output logic   head_valid,
    output instr_t head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    instr_t            mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              do_push, do_pop;

    assign full       = (count == CNT_W'(DEPTH));
    assign head_valid = (count != '0);
    assign head       = mem[rd_ptr];
    assign do_push    = push && !full;
    assign do_pop     = pop && head_valid;

    function automatic logic [PTR_W-1:0] next_ptr(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_instr;
                wr_ptr      <= next_ptr(wr_ptr);
            end
            if (do_pop)
                rd_ptr <= next_ptr(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_full_ignores_push_r1: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == CNT_W'(DEPTH)) && $stable(wr_ptr));

endmodule

// File: rtl/issue_arbiter.sv
module issue_arbiter
    import smt_issue_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_THREADS-1:0]  head_valid,
    input  unit_class_e             head_unit [NUM_THREADS],
    input  logic [NUM_UNITS-1:0]    unit_busy,
    output logic [NUM_THREADS-1:0]  grant,
    output logic                    iss_valid,
    output logic                    iss_tid
);
    logic [NUM_THREADS-1:0] can;
    logic                   prio;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_can
        assign can[t] = !rst && head_valid[t]
                        && ((unit_onehot(head_unit[t]) & unit_busy) == '0);
    end

    always_comb begin
        iss_valid = |can;
        if (can == 2'b11)
            iss_tid = prio;
        else
            iss_tid = can[1];
        grant = '0;
        if (iss_valid)
            grant[iss_tid] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            prio <= 1'b0;
        else if (iss_valid)
            prio <= ~iss_tid;
    end

    p_alternate_r2: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && can == 2'b11 && $past(iss_valid) && !$past(rst))
            |-> (iss_tid != $past(iss_tid)));

    p_skip_stalled_r3: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> can[iss_tid]);

    p_hold_prio_r4: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |=> $stable(prio));

    p_grant_single_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

endmodule

// File: rtl/thread_state.sv
module thread_state
    import smt_issue_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [REG_AW-1:0]  waddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [REG_AW-1:0]  raddr,
    output logic [DATA_W-1:0]  rdata,
    output logic [PC_W-1:0]    pc
);
    localparam int NREG = 1 << REG_AW;

    logic [DATA_W-1:0] regs [NREG];

    assign rdata = regs[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
            for (int i = 0; i < NREG; i++)
                regs[i] <= '0;
        end else if (we) begin
            pc          <= pc + 1'b1;
            regs[waddr] <= wdata;
        end
    end

    p_pc_step_r7: assert property (@(posedge clk) disable iff (rst)
        we |=> (pc == $past(pc) + 1'b1));

    p_pc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(pc));

endmodule

// File: rtl/smt_issue_top.sv
module smt_issue_top
    import smt_issue_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PC_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enq_valid,
    input  logic               enq_tid,
    input  logic [1:0]         enq_unit,
    input  logic [REG_AW-1:0]  enq_dest,
    input  logic [DATA_W-1:0]  enq_data,
    output logic [1:0]         q_full,
    input  logic [2:0]         unit_busy,
    output logic               iss_valid,
    output logic               iss_tid,
    output logic [2:0]         iss_unit,
    output logic [REG_AW-1:0]  iss_dest,
    output logic [DATA_W-1:0]  iss_data,
    input  logic               rd_tid,
    input  logic [REG_AW-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic [PC_W-1:0]    pc_t0,
    output logic [PC_W-1:0]    pc_t1
);
    instr_t                  enq_instr;
    instr_t                  head      [NUM_THREADS];
    unit_class_e             head_unit [NUM_THREADS];
    logic [NUM_THREADS-1:0]  head_valid;
    logic [NUM_THREADS-1:0]  grant;
    logic [DATA_W-1:0]       rdata_t   [NUM_THREADS];
    logic [PC_W-1:0]         pc_t      [NUM_THREADS];
    instr_t                  sel;

    assign enq_instr = '{unit: unit_class_e'(enq_unit), dest: enq_dest, data: enq_data};

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        thread_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk        (clk),
            .rst        (rst),
            .push       (enq_valid && (enq_tid == t[0])),
            .push_instr (enq_instr),
            .pop        (grant[t]),
            .full       (q_full[t]),
            .head_valid (head_valid[t]),
            .head       (head[t])
        );

        assign head_unit[t] = head[t].unit;

        thread_state #(.PC_W(PC_W)) u_state (
            .clk   (clk),
            .rst   (rst),
            .we    (grant[t]),
            .waddr (head[t].dest),
            .wdata (head[t].data),
            .raddr (rd_addr),
            .rdata (rdata_t[t]),
            .pc    (pc_t[t])
        );
    end

    issue_arbiter u_arb (
        .clk        (clk),
        .rst        (rst),
        .head_valid (head_valid),
        .head_unit  (head_unit),
        .unit_busy  (unit_busy),
        .grant      (grant),
        .iss_valid  (iss_valid),
        .iss_tid    (iss_tid)
    );

    assign sel      = head[iss_tid];
    assign iss_unit = iss_valid ? unit_onehot(sel.unit) : '0;
    assign iss_dest = sel.dest;
    assign iss_data = sel.data;
    assign rd_data  = rdata_t[rd_tid];
    assign pc_t0    = pc_t[0];
    assign pc_t1    = pc_t[1];

    p_route_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> ($countones(iss_unit) == 1 && (iss_unit & unit_busy) == '0));

    p_quiet_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |-> (iss_unit == '0));

endmodule

// File: tb/test_smt_issue_top.sv
module test_smt_issue_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    logic       clk = 1'b0;
    logic       rst;
    logic       enq_valid, enq_tid;
    logic [1:0] enq_unit, enq_dest;
    logic [7:0] enq_data;
    logic [1:0] q_full;
    logic [2:0] unit_busy;
    logic       iss_valid, iss_tid;
    logic [2:0] iss_unit;
    logic [1:0] iss_dest;
    logic [7:0] iss_data;
    logic       rd_tid;
    logic [1:0] rd_addr;
    logic [7:0] rd_data;
    logic [7:0] pc_t0, pc_t1;

    int tests_run = 0;
    int tests_failed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smt_issue_top i_smt_issue_top (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_tid(enq_tid), .enq_unit(enq_unit),
        .enq_dest(enq_dest), .enq_data(enq_data), .q_full(q_full),
        .unit_busy(unit_busy),
        .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_unit(iss_unit),
        .iss_dest(iss_dest), .iss_data(iss_data),
        .rd_tid(rd_tid), .rd_addr(rd_addr), .rd_data(rd_data),
        .pc_t0(pc_t0), .pc_t1(pc_t1)
    );

    // {busy[2:0], valid, tid, unit_onehot[2:0], dest[1:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        {3'b000, 1'b1, 1'b0, 3'b001, 2'd0},  // R2 both ready, thread 0 first
        {3'b000, 1'b1, 1'b1, 3'b010, 2'd0},  // R2 alternate to thread 1
        {3'b010, 1'b0, 1'b0, 3'b000, 2'd0},  // R4 both heads need busy FPU
        {3'b000, 1'b1, 1'b0, 3'b010, 2'd1},  // R4 pointer held at thread 0
        {3'b010, 1'b1, 1'b0, 3'b100, 2'd2},  // R3 thread 1 stalled, 0 out of turn
        {3'b000, 1'b1, 1'b1, 3'b010, 2'd1},  // R2 pointer moved to thread 1
        {3'b001, 1'b0, 1'b0, 3'b000, 2'd0},  // R4 ALU busy blocks both
        {3'b000, 1'b1, 1'b0, 3'b001, 2'd3},  // R5 ALU route
        {3'b000, 1'b1, 1'b1, 3'b001, 2'd2},  // R3 thread 0 empty
        {3'b000, 1'b1, 1'b1, 3'b100, 2'd3},  // R6 last thread 1 entry
        {3'b000, 1'b0, 1'b0, 3'b000, 2'd0}   // R1 dropped fifth entry absent
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic enq(logic tid, logic [1:0] unit, logic [1:0] dest, logic [7:0] data);
        @(negedge clk);
        enq_valid = 1'b1; enq_tid = tid; enq_unit = unit;
        enq_dest = dest; enq_data = data;
        @(posedge clk);
        #1 enq_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        rst = 1'b1; enq_valid = 1'b0; enq_tid = 1'b0; enq_unit = '0;
        enq_dest = '0; enq_data = '0; unit_busy = 3'b111; rd_tid = 1'b0; rd_addr = '0;
        do_reset();

        // R8 reset state
        #1;
        check("R8 q_full", q_full, 2'b00);
        check("R8 iss_valid", iss_valid, 1'b0);
        check("R8 pc_t0", pc_t0, 0);
        check("R8 pc_t1", pc_t1, 0);

        // Fill with all units busy: thread 0 ALU,FPU,LSU,ALU; thread 1 FPU,FPU,ALU,LSU
        enq(1'b0, 2'd0, 2'd0, 8'h10);
        enq(1'b1, 2'd1, 2'd0, 8'h20);
        enq(1'b0, 2'd1, 2'd1, 8'h11);
        enq(1'b1, 2'd1, 2'd1, 8'h21);
        enq(1'b0, 2'd2, 2'd2, 8'h12);
        enq(1'b1, 2'd0, 2'd2, 8'h22);
        enq(1'b0, 2'd0, 2'd3, 8'h13);
        #1 check("R1 only thread 0 full", q_full, 2'b01);
        enq(1'b1, 2'd2, 2'd3, 8'h23);
        #1 check("R1 both full", q_full, 2'b11);
        enq(1'b0, 2'd0, 2'd0, 8'hEE);  // R1 ignored: queue 0 full
        #1 check("R3 all busy no issue", iss_valid, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            unit_busy = VEC[i][9:7];
            #1;
            check($sformatf("R2/R3/R4 vec%0d valid", i), iss_valid, VEC[i][6]);
            if (VEC[i][6]) begin
                check($sformatf("R6 vec%0d tid", i), iss_tid, VEC[i][5]);
                check($sformatf("R5 vec%0d unit", i), iss_unit, VEC[i][4:2]);
                check($sformatf("R6 vec%0d dest", i), iss_dest, VEC[i][1:0]);
                check($sformatf("R6 vec%0d data", i), iss_data,
                      (VEC[i][5] ? 8'h20 : 8'h10) + VEC[i][1:0]);
            end else begin
                check($sformatf("R4 vec%0d unit idle", i), iss_unit, 3'b000);
            end
        end

        // R7 per-thread writeback, no cross-thread writes
        @(negedge clk);
        for (int t = 0; t < 2; t++) begin
            for (int r = 0; r < 4; r++) begin
                rd_tid = t[0]; rd_addr = r[1:0];
                #1 check($sformatf("R7 reg t%0d r%0d", t, r), rd_data,
                         (t == 1 ? 8'h20 : 8'h10) + r);
            end
        end
        check("R7 pc_t0", pc_t0, 4);
        check("R7 pc_t1", pc_t1, 4);

        // Leave the pointer on thread 1, then reset
        unit_busy = 3'b111;
        enq(1'b0, 2'd3, 2'd1, 8'h55);
        @(negedge clk);
        unit_busy = 3'b000;
        #1;
        check("R5 reserved code to ALU", iss_unit, 3'b001);
        check("R9 next cycle issue", iss_valid, 1'b1);
        @(posedge clk);
        #1 check("R7 pc_t0 step", pc_t0, 5);
        check("R7 pc_t1 unchanged", pc_t1, 4);

        do_reset();
        #1;
        rd_tid = 1'b0; rd_addr = 2'd1;
        #1 check("R8 reg cleared", rd_data, 8'h00);
        check("R8 pc cleared", pc_t0, 0);

        // R8 thread 0 has first priority after reset
        unit_busy = 3'b111;
        enq(1'b1, 2'd0, 2'd0, 8'h31);
        enq(1'b0, 2'd0, 2'd0, 8'h30);
        @(negedge clk);
        unit_busy = 3'b000;
        #1;
        check("R8 first priority tid", iss_tid, 1'b0);
        check("R8 first priority data", iss_data, 8'h30);
        @(negedge clk);
        #1 check("R2 then thread 1", iss_tid, 1'b1);
        @(negedge clk);
        #1 check("R4 drained", iss_valid, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule